// File: doc/BRIEF.md
# Dual Latched Down-Counter Timer

This block holds two 16-bit down-counters behind a byte-wide register port with a 4-bit register select. Timer A has a 16-bit reload latch. It runs in one of two modes. In single-shot mode it raises its flag once per load. In free-running mode it raises its flag on every pass through zero and reloads from the latch each period. Timer B is a single-shot counter with an 8-bit low latch. Both counters advance on a shared tick. A parameter divides the system clock down to that tick.

An interrupt-flag register and an interrupt-enable register combine into one interrupt line. Only the timer A flag and the shift flag can drive that line. The shift flag is reserved: nothing in this block sets it. Software loads a counter by writing its high byte. It reads the live count through the count bytes, and it acknowledges timer A either by reading the count low byte or by writing ones to the flag register.

Top module: `dual_downcount_timer`

## Requirements
- R1: Timer A counts down from the loaded value to 0, then to 0xFFFF on the next tick, then reloads the latch on the tick after that. Once running, zero is reached every latch+2 ticks.
- R2: Writing select 1 puts the data byte into the upper latch byte and loads the counter with {data, latch low byte} on the same edge. Selects 0 and 1 read the live count low and high bytes.
- R3: Writing select 0, select 2 (latch low) or select 3 (latch high) changes only the latch and leaves the running count undisturbed.
- R4: With auxiliary register (select 6) bits 7:6 equal to 01, timer A sets flag bit 6 on every tick that brings its count to zero. With any other value it sets that flag only at the first zero after a load.
- R5: Writing select 4 stores timer B's low latch. Writing select 5 loads timer B with {data, low latch}. Timer B sets flag bit 5 only at the first zero after that load. Selects 4 and 5 read its live count.
- R6: Flag register (select 7) bits are 6 for timer A, 5 for timer B and 2 for shift. The interrupt output is high exactly when flag AND enable has bit 6 or bit 2 set. Timer B never drives it.
- R7: A write to the enable register (select 8) with data bit 7 set ORs data bits 6:0 into the enables. With bit 7 clear, it clears the enables whose data bits are 1. Reads return {0, enables}.
- R8: After reset, the timer A latch and count are 0xFFFF, the timer B latch is 0, the timer B count is 0xFFFF, and the flags, enables and auxiliary register are 0.
- R9: Reading select 0 clears flag bit 6. Writing a 1 to a flag bit clears that flag.
- R10: When a flag set and a software clear of the same flag fall on one edge, the flag ends set.
- R11: Counters advance once every TICK_DIV clock cycles.
- R12: The auxiliary, latch, flag and enable registers read back at selects 6, 2, 3, 7 and 8. Selects 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 4 | Register select |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe, used for read side effects |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected register contents (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
A software clear of the timer A flag can land on the same edge as the tick that brings the count to zero. The clear may come from a write of 1 to the flag register or from a read of the count low byte. The bench provokes both cases by loading a latch of 3 with one tick per clock and issuing the clear exactly when the count is 1. The flag must read back as set afterwards. A load by a count-high write always coincides with a tick, so every load check also covers the rule that the load wins over the decrement.

// File: rtl/dtmr_pkg.sv
// Shared constants for the dual down-counter timer: register selects,
// flag bit positions and the counter width.
package dtmr_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;
    localparam int ENA_W  = 7;

    localparam logic [SEL_W-1:0] SEL_A_CLO = 4'd0;
    localparam logic [SEL_W-1:0] SEL_A_CHI = 4'd1;
    localparam logic [SEL_W-1:0] SEL_A_LLO = 4'd2;
    localparam logic [SEL_W-1:0] SEL_A_LHI = 4'd3;
    localparam logic [SEL_W-1:0] SEL_B_CLO = 4'd4;
    localparam logic [SEL_W-1:0] SEL_B_CHI = 4'd5;
    localparam logic [SEL_W-1:0] SEL_AUX   = 4'd6;
    localparam logic [SEL_W-1:0] SEL_FLAG  = 4'd7;
    localparam logic [SEL_W-1:0] SEL_ENA   = 4'd8;

    localparam int FLG_A  = 6;
    localparam int FLG_B  = 5;
    localparam int FLG_SH = 2;
    localparam logic [BYTE_W-1:0] FLG_IMPL = 8'h64;
    localparam logic [BYTE_W-1:0] IRQ_SRC  = 8'h44;
    localparam logic [1:0] MODE_FREE = 2'b01;

    typedef struct packed {
        logic a_lo;
        logic a_hi;
        logic a_load;
        logic b_lo;
        logic b_load;
        logic aux;
        logic flag;
        logic ena;
    } wr_strb_t;
endpackage

// File: rtl/dtmr_tick_gen.sv
// Tick prescaler: one-cycle tick every DIV clocks. DIV of 1 gives a
// tick on every cycle. Assumes DIV >= 1.
module dtmr_tick_gen #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'((DIV > 1) ? DIV - 1 : 0);

    logic [PW-1:0] pcnt;

    // Wrapping prescale counter.
    always_ff @(posedge clk) begin
        if (!rst_n)           pcnt <= '0;
        else if (pcnt == LAST) pcnt <= '0;
        else                  pcnt <= pcnt + 1'b1;
    end

    assign tick = (pcnt == LAST);
endmodule

// File: rtl/dtmr_a_unit.sv
// Timer A: 16-bit latch plus down-counter. Sequence: load value ... 0,
// 0xFFFF, latch. Raises flag_set at zero, every time in free mode, once
// per load otherwise. A load wins over a tick on the same edge.
module dtmr_a_unit
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              load,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              free_mode,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  latch,
    output logic              wrap_st,
    output logic              zero_evt,
    output logic              flag_set
);
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic armed;

    // Latch bytes, written independently.
    always_ff @(posedge clk) begin
        if (!rst_n) latch <= ALL1;
        else begin
            if (wr_lo) latch[BYTE_W-1:0]     <= wdata;
            if (wr_hi) latch[CNT_W-1:BYTE_W] <= wdata;
        end
    end

    // Tick into zero: by decrement from 1, or by reload of a zero latch.
    assign zero_evt = tick && !load &&
                      (wrap_st ? (latch == '0) : (count == ONE));
    assign flag_set = zero_evt && (free_mode || armed);

    // Counter with the wrap state that marks 0xFFFF reached from zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= ALL1;
            wrap_st <= 1'b0;
        end else if (load) begin
            count   <= {wdata, latch[BYTE_W-1:0]};
            wrap_st <= 1'b0;
        end else if (tick) begin
            if (wrap_st) begin
                count   <= latch;
                wrap_st <= 1'b0;
            end else begin
                count   <= count - ONE;
                wrap_st <= (count == '0);
            end
        end
    end

    // Single-shot arm: set by a load, spent by the first zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b0;
        else if (load)     armed <= 1'b1;
        else if (zero_evt) armed <= 1'b0;
    end
endmodule

// File: rtl/dtmr_b_unit.sv
// Timer B: single-shot down-counter with a low-byte latch. Loading the
// high byte starts it; the first zero afterwards raises flag_set.
module dtmr_b_unit
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              load,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              flag_set
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [BYTE_W-1:0] low_lat;
    logic              armed;

    // Low latch byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     low_lat <= '0;
        else if (wr_lo) low_lat <= wdata;
    end

    assign flag_set = tick && !load && armed && (count == ONE);

    // Counter: load wins over tick; free wrap through 0xFFFF.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= {CNT_W{1'b1}};
        else if (load)  count <= {wdata, low_lat};
        else if (tick)  count <= count - ONE;
    end

    // Arm for one flag per load.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b0;
        else if (load)     armed <= 1'b1;
        else if (flag_set) armed <= 1'b0;
    end
endmodule

// File: rtl/dtmr_irq_ctrl.sv
// Flag and enable registers. Hardware sets beat software clears on the
// same edge. Only implemented flag bits (6, 5, 2) hold state.
module dtmr_irq_ctrl
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_a,
    input  logic              set_b,
    input  logic              wr_flag,
    input  logic              wr_ena,
    input  logic              rd_clr_a,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] flags,
    output logic [ENA_W-1:0]  ena,
    output logic              irq
);
    logic [BYTE_W-1:0] set_v;
    logic [BYTE_W-1:0] clr_v;

    // Gather set and clear vectors.
    always_comb begin
        set_v = '0;
        set_v[FLG_A] = set_a;
        set_v[FLG_B] = set_b;
        clr_v = wr_flag ? wdata : '0;
        if (rd_clr_a) clr_v[FLG_A] = 1'b1;
    end

    // Flag register, set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= ((flags & ~clr_v) | set_v) & FLG_IMPL;
    end

    // Enable register with bit-7 set/clear write.
    always_ff @(posedge clk) begin
        if (!rst_n) ena <= '0;
        else if (wr_ena) begin
            if (wdata[BYTE_W-1]) ena <= ena | wdata[ENA_W-1:0];
            else                 ena <= ena & ~wdata[ENA_W-1:0];
        end
    end

    assign irq = |(flags & {1'b0, ena} & IRQ_SRC);
endmodule

// File: rtl/dual_downcount_timer.sv
// Top: register decode, auxiliary mode register, read mux and the two
// timers sharing one prescaled tick. Reads are combinational; the only
// read side effect (clear of the timer A flag) acts on the rd_en edge.
module dual_downcount_timer
    import dtmr_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq
);
    wr_strb_t          strb;
    logic              tick;
    logic [BYTE_W-1:0] aux;
    logic [CNT_W-1:0]  a_count, a_latch, b_count;
    logic              a_wrap, a_zero, a_set, b_set;
    logic              a_load;
    logic [BYTE_W-1:0] flags;
    logic [ENA_W-1:0]  ena;
    logic              rd_clr_a;

    // Write strobe decode.
    always_comb begin
        strb        = '0;
        strb.a_lo   = wr_en && (reg_sel == SEL_A_CLO || reg_sel == SEL_A_LLO);
        strb.a_hi   = wr_en && (reg_sel == SEL_A_CHI || reg_sel == SEL_A_LHI);
        strb.a_load = wr_en && (reg_sel == SEL_A_CHI);
        strb.b_lo   = wr_en && (reg_sel == SEL_B_CLO);
        strb.b_load = wr_en && (reg_sel == SEL_B_CHI);
        strb.aux    = wr_en && (reg_sel == SEL_AUX);
        strb.flag   = wr_en && (reg_sel == SEL_FLAG);
        strb.ena    = wr_en && (reg_sel == SEL_ENA);
    end

    assign a_load   = strb.a_load;
    assign rd_clr_a = rd_en && (reg_sel == SEL_A_CLO);

    // Auxiliary mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)        aux <= '0;
        else if (strb.aux) aux <= wr_data;
    end

    dtmr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    dtmr_a_unit u_a (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_lo(strb.a_lo), .wr_hi(strb.a_hi), .load(a_load),
        .wdata(wr_data), .free_mode(aux[7:6] == MODE_FREE),
        .count(a_count), .latch(a_latch), .wrap_st(a_wrap),
        .zero_evt(a_zero), .flag_set(a_set)
    );

    dtmr_b_unit u_b (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_lo(strb.b_lo), .load(strb.b_load), .wdata(wr_data),
        .count(b_count), .flag_set(b_set)
    );

    dtmr_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .set_a(a_set), .set_b(b_set),
        .wr_flag(strb.flag), .wr_ena(strb.ena), .rd_clr_a(rd_clr_a),
        .wdata(wr_data), .flags(flags), .ena(ena), .irq(irq)
    );

    // Read mux.
    always_comb begin
        case (reg_sel)
            SEL_A_CLO: rd_data = a_count[BYTE_W-1:0];
            SEL_A_CHI: rd_data = a_count[CNT_W-1:BYTE_W];
            SEL_A_LLO: rd_data = a_latch[BYTE_W-1:0];
            SEL_A_LHI: rd_data = a_latch[CNT_W-1:BYTE_W];
            SEL_B_CLO: rd_data = b_count[BYTE_W-1:0];
            SEL_B_CHI: rd_data = b_count[CNT_W-1:BYTE_W];
            SEL_AUX:   rd_data = aux;
            SEL_FLAG:  rd_data = flags;
            SEL_ENA:   rd_data = {1'b0, ena};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dtmr_checker.sv
// Assertion checker for dual_downcount_timer, attached by bind below.
module dtmr_checker #(
    parameter int TICK_DIV = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  reg_sel,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic        irq,
    input logic        tick,
    input logic [15:0] a_count,
    input logic [15:0] a_latch,
    input logic        a_wrap,
    input logic        a_zero,
    input logic        a_load,
    input logic        free_mode,
    input logic [7:0]  flags,
    input logic [6:0]  ena
);
    // R1: from the wrap state a tick reloads the latch.
    assert_wrap_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick && a_wrap && !a_load |=> a_count == $past(a_latch));

    // R1: a tick from zero gives 0xFFFF in the wrap state.
    assert_zero_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !a_wrap && !a_load && a_count == 16'h0000
        |=> a_count == 16'hFFFF && a_wrap);

    // R2: a count-high write loads {data, latch low}.
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        a_load |=> a_count == {$past(wr_data), $past(a_latch[7:0])});

    // R3: latch-only writes leave the count decrementing.
    assert_latch_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (reg_sel == 4'd0 || reg_sel == 4'd2 || reg_sel == 4'd3)
        && tick && !a_wrap && a_count != 16'h0000
        |=> a_count == $past(a_count) - 16'd1);

    // R4: in free mode every zero sets the timer A flag.
    assert_free_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        a_zero && free_mode |=> flags[6]);

    // R10: a same-edge clear by write loses to the set.
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        a_zero && free_mode && wr_en && reg_sel == 4'd7 && wr_data[6]
        |=> flags[6]);

    // R6: without timer A or shift flags the interrupt stays low.
    assert_irq_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[6] && !flags[2] |-> !irq);

    // R7: a set-style enable write sets the named bits.
    assert_ena_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && reg_sel == 4'd8 && wr_data[7]
        |=> (ena & $past(wr_data[6:0])) == $past(wr_data[6:0]));

    // R7: a clear-style enable write clears the named bits.
    assert_ena_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && reg_sel == 4'd8 && !wr_data[7]
        |=> (ena & $past(wr_data[6:0])) == 7'd0);

    // R11: with division above one, ticks never fall on adjacent cycles.
    assert_tick_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (TICK_DIV > 1) && tick |=> !tick);
endmodule

bind dual_downcount_timer dtmr_checker #(.TICK_DIV(TICK_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .irq(irq), .tick(tick), .a_count(a_count),
    .a_latch(a_latch), .a_wrap(a_wrap), .a_zero(a_zero), .a_load(a_load),
    .free_mode(aux[7:6] == 2'b01), .flags(flags), .ena(ena)
);

// File: tb/sim_dual_downcount_timer.sv
`timescale 1ns/1ps
// Bench: u0 ticks every clock (exact cycle prediction), u1 divides by 4.
module sim_dual_downcount_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_sel = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd0, rd1;
    logic       irq0, irq1;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    dual_downcount_timer #(.TICK_DIV(1)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd0), .irq(irq0));

    dual_downcount_timer #(.TICK_DIV(4)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd1), .irq(irq1));

    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_PK = 3'd2,
                           OP_WT = 3'd3, OP_IQ = 3'd4;
    localparam int NV = 59;
    // {op, sel, data, expected, requirement number}
    localparam logic [26:0] TBL [0:NV-1] = '{
        {OP_WR, 4'd8, 8'hC0, 8'h00, 4'd7},   // R7 set bit 6
        {OP_PK, 4'd8, 8'h00, 8'h40, 4'd7},
        {OP_WR, 4'd8, 8'h24, 8'h00, 4'd7},   // R7 bit 7 clear: clears 5,2 (none set)
        {OP_PK, 4'd8, 8'h00, 8'h40, 4'd7},
        {OP_WR, 4'd8, 8'hA4, 8'h00, 4'd7},   // R7 set 5,2
        {OP_PK, 4'd8, 8'h00, 8'h64, 4'd7},
        {OP_WR, 4'd2, 8'h05, 8'h00, 4'd3},   // R3 latch low
        {OP_WR, 4'd8, 8'h20, 8'h00, 4'd7},   // R7 clear bit 5 -> 0x44
        {OP_PK, 4'd8, 8'h00, 8'h44, 4'd7},
        {OP_WR, 4'd3, 8'h00, 8'h00, 4'd3},   // R3 latch high
        {OP_PK, 4'd2, 8'h00, 8'h05, 4'd12},
        {OP_PK, 4'd3, 8'h00, 8'h00, 4'd12},
        {OP_WR, 4'd1, 8'h00, 8'h00, 4'd2},   // R2 load 0x0005
        {OP_PK, 4'd0, 8'h00, 8'h05, 4'd2},
        {OP_PK, 4'd1, 8'h00, 8'h00, 4'd2},
        {OP_WT, 4'd0, 8'd3,  8'h00, 4'd2},
        {OP_PK, 4'd0, 8'h00, 8'h02, 4'd2},   // R2 live count
        {OP_IQ, 4'd0, 8'h00, 8'h00, 4'd6},
        {OP_WT, 4'd0, 8'd2,  8'h00, 4'd1},
        {OP_PK, 4'd0, 8'h00, 8'h00, 4'd1},   // R1 zero
        {OP_PK, 4'd7, 8'h00, 8'h40, 4'd6},   // R6 bit 6
        {OP_IQ, 4'd0, 8'h00, 8'h01, 4'd6},
        {OP_WT, 4'd0, 8'd1,  8'h00, 4'd1},
        {OP_PK, 4'd0, 8'h00, 8'hFF, 4'd1},   // R1 0xFFFF
        {OP_PK, 4'd1, 8'h00, 8'hFF, 4'd1},
        {OP_WT, 4'd0, 8'd1,  8'h00, 4'd1},
        {OP_PK, 4'd0, 8'h00, 8'h05, 4'd1},   // R1 reload
        {OP_RD, 4'd0, 8'h00, 8'h05, 4'd9},   // R9 read clears
        {OP_PK, 4'd7, 8'h00, 8'h00, 4'd9},
        {OP_IQ, 4'd0, 8'h00, 8'h00, 4'd9},
        {OP_WT, 4'd0, 8'd4,  8'h00, 4'd4},
        {OP_PK, 4'd0, 8'h00, 8'h00, 4'd4},
        {OP_PK, 4'd7, 8'h00, 8'h00, 4'd4},   // R4 single shot: no second flag
        {OP_WR, 4'd6, 8'h40, 8'h00, 4'd4},   // R4 free mode
        {OP_PK, 4'd6, 8'h00, 8'h40, 4'd12},
        {OP_WT, 4'd0, 8'd6,  8'h00, 4'd4},
        {OP_PK, 4'd0, 8'h00, 8'h00, 4'd4},
        {OP_PK, 4'd7, 8'h00, 8'h40, 4'd4},
        {OP_WR, 4'd7, 8'h40, 8'h00, 4'd9},   // R9 write-one clear
        {OP_PK, 4'd7, 8'h00, 8'h00, 4'd9},
        {OP_WT, 4'd0, 8'd6,  8'h00, 4'd1},   // R1 period 7
        {OP_PK, 4'd7, 8'h00, 8'h40, 4'd1},
        {OP_WR, 4'd6, 8'h00, 8'h00, 4'd4},
        {OP_WR, 4'd7, 8'h60, 8'h00, 4'd9},
        {OP_PK, 4'd7, 8'h00, 8'h00, 4'd9},
        {OP_WR, 4'd4, 8'h03, 8'h00, 4'd5},   // R5 B low latch
        {OP_WR, 4'd5, 8'h00, 8'h00, 4'd5},   // R5 B load 3
        {OP_PK, 4'd4, 8'h00, 8'h03, 4'd5},
        {OP_WT, 4'd0, 8'd3,  8'h00, 4'd5},
        {OP_PK, 4'd4, 8'h00, 8'h00, 4'd5},
        {OP_PK, 4'd7, 8'h00, 8'h20, 4'd6},   // R6 bit 5
        {OP_WR, 4'd8, 8'hA0, 8'h00, 4'd7},
        {OP_PK, 4'd8, 8'h00, 8'h64, 4'd7},
        {OP_IQ, 4'd0, 8'h00, 8'h00, 4'd6},   // R6 B never drives irq
        {OP_WT, 4'd0, 8'd10, 8'h00, 4'd5},
        {OP_PK, 4'd7, 8'h00, 8'h20, 4'd5},   // R5 no second flag
        {OP_WR, 4'd7, 8'h20, 8'h00, 4'd9},
        {OP_PK, 4'd7, 8'h00, 8'h00, 4'd9},
        {OP_PK, 4'd15,8'h00, 8'h00, 4'd12}   // R12 unused select
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        reg_sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [7:0] v);
        reg_sel = s; rd_en = 1'b1;
        #0.1 v = rd0;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pk(input logic [3:0] s, output logic [7:0] v);
        reg_sel = s;
        #0.1 v = rd0;
    endtask

    task automatic pk1(output logic [15:0] v);
        reg_sel = 4'd0;
        #0.1 v[7:0] = rd1;
        reg_sel = 4'd1;
        #0.1 v[15:8] = rd1;
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0]  v;
        logic [15:0] a, b, c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset values, before any edge after release
        pk(4'd0, v); chk("R8 A count lo", {8'h0, v}, 16'hFF);
        pk(4'd1, v); chk("R8 A count hi", {8'h0, v}, 16'hFF);
        pk(4'd2, v); chk("R8 A latch lo", {8'h0, v}, 16'hFF);
        pk(4'd3, v); chk("R8 A latch hi", {8'h0, v}, 16'hFF);
        pk(4'd4, v); chk("R8 B count lo", {8'h0, v}, 16'hFF);
        pk(4'd5, v); chk("R8 B count hi", {8'h0, v}, 16'hFF);
        pk(4'd6, v); chk("R8 aux", {8'h0, v}, 16'h00);
        pk(4'd7, v); chk("R8 flags", {8'h0, v}, 16'h00);
        pk(4'd8, v); chk("R8 enables", {8'h0, v}, 16'h00);
        chk("R8 irq", {15'h0, irq0}, 16'h0);
        wr(4'd5, 8'h12);
        pk(4'd5, v); chk("R8 B load hi", {8'h0, v}, 16'h12);
        pk(4'd4, v); chk("R8 B latch low is 0", {8'h0, v}, 16'h00);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] op;
            logic [3:0] s;
            logic [7:0] d, e;
            string      tag;
            {op, s, d, e} = TBL[i][26:4];
            tag = $sformatf("R%0d vec%0d", TBL[i][3:0], i);
            case (op)
                OP_WR: wr(s, d);
                OP_RD: begin rd(s, v); chk(tag, {8'h0, v}, {8'h0, e}); end
                OP_PK: begin pk(s, v); chk(tag, {8'h0, v}, {8'h0, e}); end
                OP_WT: wt(int'(d));
                default: chk(tag, {15'h0, irq0}, {15'h0, e[0]});
            endcase
        end

        // R10: clear by write and by read on the zero edge; set wins
        wr(4'd2, 8'h03); wr(4'd1, 8'h00); wr(4'd6, 8'h40); wt(1);
        wr(4'd7, 8'h40);
        pk(4'd7, v); chk("R10 write clear vs set", {8'h0, v}, 16'h40);
        wr(4'd7, 8'h40);
        pk(4'd7, v); chk("R9 cleared", {8'h0, v}, 16'h00);
        wt(3);
        rd(4'd0, v); chk("R10 read value", {8'h0, v}, 16'h01);
        pk(4'd7, v); chk("R10 read clear vs set", {8'h0, v}, 16'h40);
        wr(4'd6, 8'h00); wr(4'd7, 8'h40);

        // R3: latch writes while counting leave the count alone
        wr(4'd2, 8'h10); wr(4'd1, 8'h00); wt(2);
        wr(4'd2, 8'h33);
        pk(4'd0, v); chk("R3 latch lo no reload", {8'h0, v}, 16'h0D);
        wr(4'd3, 8'h01);
        pk(4'd0, v); chk("R3 latch hi no reload", {8'h0, v}, 16'h0C);
        pk(4'd1, v); chk("R3 count hi", {8'h0, v}, 16'h00);
        pk(4'd3, v); chk("R12 latch hi readback", {8'h0, v}, 16'h01);
        wt(13);
        pk(4'd1, v); chk("R1 wrap hi", {8'h0, v}, 16'hFF);
        wt(1);
        pk(4'd1, v); chk("R1 reload new latch hi", {8'h0, v}, 16'h01);
        pk(4'd0, v); chk("R1 reload new latch lo", {8'h0, v}, 16'h33);
        wr(4'd0, 8'h44);
        pk(4'd0, v); chk("R3 count-lo write", {8'h0, v}, 16'h32);
        pk(4'd2, v); chk("R3 count-lo write hits latch", {8'h0, v}, 16'h44);

        // R11: divided instance steps once per four clocks
        wr(4'd2, 8'h00); wr(4'd1, 8'h80);
        pk1(a); wt(8); pk1(b); wt(40); pk1(c);
        chk("R11 8 clocks", a - b, 16'd2);
        chk("R11 40 clocks", b - c, 16'd10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule